// File: doc/BRIEF.md
# Two-Phase Vacuum-Fluorescent Display Multiplexer

This block sequences a vacuum-fluorescent display whose segments are shared between two grid phases. A host loads two banks of raw segment bits, one per grid, into shadow storage. The block copies both shadow banks into the active banks only at a frame boundary, so a frame never mixes old and new data. It then drives one grid at a time and presents the matching bank on the segment lines, with no character decoding.

A free-running frame counter advances once per oscillator clock. One frame is two equal phases. Each phase opens with a short guard interval in which both grids are dark. The grid is then lit for a number of clocks taken from a host-written dimmer setting. A blanking input darkens the segments at once. A host-written sleep bit stops the frame counter and darkens every output.

Top module: `vfd_half_duty_mux`

## Requirements
- R1: After reset, both grid outputs and all segment outputs are 0, the frame counter is at the start of phase 0, both banks hold 0, the dimmer holds its maximum (PHASE_CLKS-GUARD) and sleep is off.
- R2: A frame lasts 2*PHASE_CLKS clocks (4096 by default). Frame positions 0 to PHASE_CLKS-1 are phase 0 and drive grid[0]; the remaining positions are phase 1 and drive grid[1]. The two grids are never high together.
- R3: In the first GUARD clocks of each phase, both grids are 0.
- R4: After the guard, the phase's grid is high for exactly the dimmer value in clocks, capped by the phase length. A dimmer value of 0 keeps both grids dark. The dimmer is written through ctl_wr/ctl_dim and applies from the next clock.
- R5: While a grid is high, the segment outputs equal the active bank of that phase (bank 0 for grid[0], bank 1 for grid[1]). While both grids are low, the segment outputs are 0.
- R6: A write with wr_en high stores wr_data in shadow bank wr_bank. The active banks take the shadow contents only on the clock that ends a frame (or on any clock while asleep), so a write made during a frame appears in the next frame.
- R7: While blank is high, all segment outputs are 0 in the same cycle, and the grids keep sequencing. Writes made while blank is high are still stored.
- R8: A ctl_wr with ctl_sleep=1 enters sleep from the next clock. In sleep the frame counter is held at frame start and all outputs are 0. After sleep is cleared, sequencing restarts at the start of phase 0 and shows the latest shadow data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blank | input | 1 | Forces all segments dark while high |
| wr_en | input | 1 | Display data write strobe |
| wr_bank | input | 1 | Target bank: 0 for grid 0, 1 for grid 1 |
| wr_data | input | SEG_W | Segment bits for the selected bank |
| ctl_wr | input | 1 | Control write strobe |
| ctl_sleep | input | 1 | Sleep bit loaded on ctl_wr |
| ctl_dim | input | DIM_W | Lit clocks per phase, loaded on ctl_wr |
| grid | output | 2 | Grid drives, one-hot or zero |
| seg | output | SEG_W | Segment drives |

## Verification
The bench runs whole frames with distinct, non-symmetric patterns in the two banks, so a swap of banks or phases shows up. It makes a write part-way through a frame, which separates a correct frame-boundary copy from an immediate one. Dimmer values of maximum, 100 and 0 test the lit window against the guard interval and against the phase length. Blanking with a write pending, and sleep entered mid-frame, show whether the counter holds, whether the data still lands, and whether sequencing restarts at phase 0.

// File: rtl/vfd_half_duty_mux.sv
module vfd_half_duty_mux #(
  parameter int SEG_W      = 41,
  parameter int PHASE_CLKS = 2048,
  parameter int GUARD      = 4,
  localparam int PW    = $clog2(PHASE_CLKS),
  localparam int CW    = PW + 1,
  localparam int DIM_W = PW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             ctl_wr,
  input  logic             ctl_sleep,
  input  logic [DIM_W-1:0] ctl_dim,
  output logic [1:0]       grid,
  output logic [SEG_W-1:0] seg
);
  localparam logic [DIM_W-1:0] DIM_MAX = DIM_W'(PHASE_CLKS - GUARD);

  logic [CW-1:0]    cnt;
  logic             sleep_q;
  logic [DIM_W-1:0] dim_q;
  logic [SEG_W-1:0] shadow [2];
  logic [SEG_W-1:0] active [2];

  wire              ph       = cnt[CW-1];
  wire [DIM_W-1:0]  pos      = {1'b0, cnt[PW-1:0]};
  wire              in_guard = pos < DIM_W'(GUARD);
  wire [DIM_W-1:0]  rel      = pos - DIM_W'(GUARD);
  wire              lit      = !sleep_q && !in_guard && (rel < dim_q);
  wire              frame_end = &cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      sleep_q <= 1'b0;
      dim_q   <= DIM_MAX;
      for (int b = 0; b < 2; b++) begin
        shadow[b] <= '0;
        active[b] <= '0;
      end
    end else begin
      cnt <= sleep_q ? '0 : cnt + 1'b1;
      if (ctl_wr) begin
        sleep_q <= ctl_sleep;
        dim_q   <= ctl_dim;
      end
      if (wr_en) shadow[wr_bank] <= wr_data;
      if (sleep_q || frame_end)
        for (int b = 0; b < 2; b++) active[b] <= shadow[b];
    end
  end

  assign grid = lit ? (ph ? 2'b10 : 2'b01) : 2'b00;
  assign seg  = (lit && !blank) ? active[ph] : '0;
endmodule

module vfd_half_duty_mux_chk #(
  parameter int SEG_W = 41,
  parameter int CW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blank,
  input logic             sleep_q,
  input logic [CW-1:0]    cnt,
  input logic [1:0]       grid,
  input logic [SEG_W-1:0] seg
);
  p_grid_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid));
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_q && (&cnt)) |=> (cnt == '0));
  p_guard_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grid[0] |=> !grid[1]);
  p_guard_gap_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grid[1] |=> !grid[0]);
  p_dark_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grid == 2'b00) |-> (seg == '0));
  p_blank_seg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (seg == '0));
  p_sleep_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |-> (grid == 2'b00 && seg == '0));
  p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |=> (cnt == '0));
endmodule

bind vfd_half_duty_mux vfd_half_duty_mux_chk #(.SEG_W(SEG_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .blank(blank), .sleep_q(sleep_q),
  .cnt(cnt), .grid(grid), .seg(seg));

// File: tb/sim_vfd_half_duty_mux.sv
module sim_vfd_half_duty_mux;
  localparam int SW = 41;
  localparam int PH = 2048;
  localparam int FR = 2 * PH;
  localparam int GD = 4;

  logic clk = 0, rst_n = 0, blank = 0, wr_en = 0, wr_bank = 0;
  logic ctl_wr = 0, ctl_sleep = 0;
  logic [SW-1:0] wr_data = '0;
  logic [11:0] ctl_dim = '0;
  logic [1:0] grid;
  logic [SW-1:0] seg;

  vfd_half_duty_mux u0 (.clk(clk), .rst_n(rst_n), .blank(blank), .wr_en(wr_en),
    .wr_bank(wr_bank), .wr_data(wr_data), .ctl_wr(ctl_wr), .ctl_sleep(ctl_sleep),
    .ctl_dim(ctl_dim), .grid(grid), .seg(seg));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int mcnt = 0, mdim = PH - GD;
  bit msl = 0;
  logic [SW-1:0] msh [2];
  logic [SW-1:0] mact [2];
  bit pend = 0;

  // behavioural reference: positions in a frame, two banks, copy at frame end
  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt = 0; mdim = PH - GD; msl = 0; pend = 0;
      msh[0] = '0; msh[1] = '0; mact[0] = '0; mact[1] = '0;
    end else begin
      bit was_sl;
      was_sl = msl;
      if (was_sl || mcnt == FR - 1) begin
        mact[0] = msh[0]; mact[1] = msh[1]; pend = 0;
      end
      if (wr_en) begin msh[wr_bank] = wr_data; pend = 1; end
      if (ctl_wr) begin msl = ctl_sleep; mdim = int'(ctl_dim); end
      mcnt = was_sl ? 0 : (mcnt + 1) % FR;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (pos %0d)", req, act, exp, mcnt);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int pos, ph;
      bit on;
      logic [1:0] eg;
      logic [SW-1:0] es;
      string tg;
      pos = mcnt % PH; ph = mcnt / PH;
      on = !msl && pos >= GD && (pos - GD) < mdim;
      eg = on ? (ph ? 2'b10 : 2'b01) : 2'b00;
      es = (on && !blank) ? mact[ph] : '0;
      if (msl) tg = "R8";
      else if (pos < GD) tg = "R3";
      else if (mdim < PH - GD) tg = "R4";
      else tg = "R2";
      check(tg, 64'(grid), 64'(eg));
      if (msl) tg = "R8";
      else if (blank) tg = "R7";
      else if (pend) tg = "R6";
      else tg = "R5";
      check(tg, 64'(seg), 64'(es));
    end
  end

  task automatic go(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_pos(int p);
    while (mcnt != p) @(negedge clk);
  endtask
  task automatic wr(bit b, logic [SW-1:0] d);
    @(negedge clk); wr_en = 1; wr_bank = b; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic ctl(bit s, int d);
    @(negedge clk); ctl_wr = 1; ctl_sleep = s; ctl_dim = 12'(d);
    @(negedge clk); ctl_wr = 0;
  endtask

  localparam logic [SW-1:0] PA = 41'h1_2345_6789A;
  localparam logic [SW-1:0] PB = 41'h0_F0F0_0F0F5;
  localparam logic [SW-1:0] PC = 41'h1_8000_00001;
  localparam logic [SW-1:0] PD = 41'h0_5555_AAAA3;

  initial begin
    go(3);
    @(negedge clk); rst_n = 1;
    #1;
    check("R1", 64'(grid), 64'd0);
    check("R1", 64'(seg), 64'd0);
    wr(0, PA); wr(1, PB);
    wait_pos(GD + 10); #1;
    check("R6", 64'(seg), 64'd0);
    wait_pos(FR - 1); go(1);
    wait_pos(GD + 20); #1;
    check("R5", 64'(seg), 64'(PA));
    check("R2", 64'(grid), 64'd1);
    wr(0, PC);
    #1; check("R6", 64'(seg), 64'(PA));
    wait_pos(PH + GD + 5); #1;
    check("R2", 64'(grid), 64'd2);
    check("R5", 64'(seg), 64'(PB));
    wait_pos(1); wait_pos(GD + 1); #1;
    check("R6", 64'(seg), 64'(PC));
    ctl(0, 100);
    wait_pos(FR - 10); wait_pos(PH + GD + 99); #1;
    check("R4", 64'(grid), 64'd2);
    go(1); #1;
    check("R4", 64'(grid), 64'd0);
    ctl(0, 0);
    go(3000);
    ctl(0, PH - GD);
    wait_pos(200);
    blank = 1;
    wr(1, PD);
    #1; check("R7", 64'(seg), 64'd0);
    check("R7", 64'(grid), 64'd1);
    wait_pos(PH + 50);
    blank = 0;
    wait_pos(PH + 60); wait_pos(PH + 70); #1;
    check("R7", 64'(seg), 64'(PB));
    wait_pos(FR - 1); wait_pos(PH + 80); #1;
    check("R7", 64'(seg), 64'(PD));
    wait_pos(700);
    ctl(1, PH - GD);
    wr(0, PB);
    go(500); #1;
    check("R8", 64'(grid), 64'd0);
    check("R8", 64'(seg), 64'd0);
    ctl(0, PH - GD);
    wait_pos(GD + 3); #1;
    check("R8", 64'(seg), 64'(PB));
    go(FR + 50);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule